// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a 4 KB data cache placed between a processor's load/store port and a word-wide port to the next memory level. Each 32-bit word address is split into a tag, a set index, a subline index and a word index. Every set holds two ways, and each way stores a tag, a valid bit, a dirty bit and eight data words. One replacement bit per set names the way to evict next.

A read hit or write hit completes without a stall, and read data arrives on the cycle after the request is accepted. A write hit updates the cached word and marks the line dirty. It sends nothing outward. A read miss raises the stall. If the chosen victim is dirty, its eight words are written out first. The line is then fetched word by word into the victim way, and the held request completes as a hit. A write miss sends one word write outward and does not allocate a line. A separate 3-bit mode register accepts only its two legal encodings.

Top module: `dcache2w`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses. The mode register reads 000b. No memory request is raised and the stall is low while the CPU is idle.
- R2: Address bits 1:0 are ignored. Bit 2 selects the word in an 8-byte subline, bits 4:3 select the subline, bits 10:5 select one of 64 sets, and bits 31:11 are the tag. Addresses that differ only in bits 1:0 return the same word.
- R3: A read hit raises no stall and causes no memory traffic. `cpu_rvalid` is high and `cpu_rdata` holds the word in the cycle after the request is accepted.
- R4: A write hit updates the cached word and sets the line's dirty bit. It causes no memory traffic and leaves the next level unchanged.
- R5: A read miss stalls the CPU and fetches the 32-byte line as eight word reads. The reads run in ascending address order, from the line base to base+28. The line goes into the set's replacement way, and the held read then returns the fetched word.
- R6: When the replacement way is valid and dirty, its eight words are written to the victim's own line address before the fill starts. A clean victim is dropped with no write.
- R7: Each hit or fill sets the set's replacement bit to the way that was not accessed.
- R8: A write miss issues exactly one word write to the next level and allocates nothing. A later read of that address misses.
- R9: A mode write with value 000b or 010b is stored. Any other value is ignored and the register keeps its old value.
- R10: A memory request holds its address, direction and write data until `mem_ack`. Each acknowledge moves exactly one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, held while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_stall | output | 1 | Request cannot complete this cycle |
| cpu_rdata | output | 32 | Load data |
| cpu_rvalid | output | 1 | Load data valid (one cycle) |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_in | input | 3 | Proposed mode value |
| mode_out | output | 3 | Current mode value |
| mem_req | output | 1 | Next-level word request |
| mem_we | output | 1 | 1 = word write, 0 = word read |
| mem_addr | output | 32 | Word address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Current word transfer done |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
A request is accepted at the first rising edge where `cpu_req` is high and `cpu_stall` is low. The registered load data and `cpu_rvalid` appear after that same edge. The bench drives inputs on falling edges and reads the stall 1 ns before the next rising edge. It then reads `cpu_rdata` and `cpu_rvalid` at the following falling edge, one register after acceptance. The bench memory model counts read and write beats and logs their addresses. Miss, write-back and write-forward traffic is therefore checked as exact beat counts and addresses after each access completes. The mode register is registered once, so `mode_out` is sampled on the falling edge after the write strobe.

// File: rtl/dc_pkg.sv
package dc_pkg;
    localparam int AW = 32;
    localparam int DW = 32;

    localparam logic [2:0] MODE_NORMAL = 3'b000;
    localparam logic [2:0] MODE_ALT    = 3'b010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WB,
        ST_FILL,
        ST_WFWD,
        ST_WDONE
    } dc_state_e;
endpackage

// File: rtl/dc_addr_split.sv
module dc_addr_split #(
    parameter int SET_BITS  = 6,
    parameter int SUB_BITS  = 2,
    parameter int WORD_BITS = 1
) (
    input  logic [31:0]                              addr,
    output logic [31-SET_BITS-SUB_BITS-WORD_BITS-2:0] tag,
    output logic [SET_BITS-1:0]                      set_idx,
    output logic [SUB_BITS+WORD_BITS-1:0]            line_word
);
    localparam int OFS = SUB_BITS + WORD_BITS + 2;

    logic [SUB_BITS-1:0]  sub_idx;
    logic [WORD_BITS-1:0] word_idx;
    logic                 unused_byte;

    always_comb begin
        word_idx    = addr[2 +: WORD_BITS];
        sub_idx     = addr[2+WORD_BITS +: SUB_BITS];
        set_idx     = addr[OFS +: SET_BITS];
        tag         = addr[31:OFS+SET_BITS];
        line_word   = {sub_idx, word_idx};
        unused_byte = ^addr[1:0];
    end
endmodule

// File: rtl/dc_tags.sv
module dc_tags #(
    parameter int SET_BITS = 6,
    parameter int TAG_BITS = 21
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SET_BITS-1:0]      rd_set,
    output logic [1:0][TAG_BITS-1:0] rd_tag,
    output logic [1:0]               rd_valid,
    output logic [1:0]               rd_dirty,
    output logic                     rd_lru,
    input  logic                     fill_en,
    input  logic                     fill_way,
    input  logic [TAG_BITS-1:0]      fill_tag,
    input  logic                     dirty_en,
    input  logic                     dirty_way,
    input  logic                     lru_en,
    input  logic                     lru_used_way
);
    localparam int SETS = 1 << SET_BITS;

    typedef struct packed {
        logic [SETS-1:0][1:0][TAG_BITS-1:0] tag;
        logic [SETS-1:0][1:0]               valid;
        logic [SETS-1:0][1:0]               dirty;
        logic [SETS-1:0]                    lru;
    } tag_regs_t;

    tag_regs_t tr_d, tr_q;

    always_comb begin
        tr_d = tr_q;
        if (fill_en) begin
            tr_d.tag[rd_set][fill_way]   = fill_tag;
            tr_d.valid[rd_set][fill_way] = 1'b1;
            tr_d.dirty[rd_set][fill_way] = 1'b0;
        end
        if (dirty_en) begin
            tr_d.dirty[rd_set][dirty_way] = 1'b1;
        end
        if (lru_en) begin
            tr_d.lru[rd_set] = ~lru_used_way;
        end
        rd_tag   = tr_q.tag[rd_set];
        rd_valid = tr_q.valid[rd_set];
        rd_dirty = tr_q.dirty[rd_set];
        rd_lru   = tr_q.lru[rd_set];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tr_q <= '0;
        else        tr_q <= tr_d;
    end

    // A fill and a dirty mark never target the store in the same cycle
    assert_no_fill_dirty_clash_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_en && dirty_en));
endmodule

// File: rtl/dc_data.sv
module dc_data #(
    parameter int SET_BITS = 6,
    parameter int LW_BITS  = 3
) (
    input  logic                clk,
    input  logic [SET_BITS-1:0] rd_set,
    input  logic                rd_way,
    input  logic [LW_BITS-1:0]  rd_lw,
    output logic [31:0]         rd_data,
    input  logic                wr_en,
    input  logic                wr_way,
    input  logic [LW_BITS-1:0]  wr_lw,
    input  logic [31:0]         wr_data
);
    localparam int IDX_BITS = SET_BITS + 1 + LW_BITS;
    localparam int DEPTH    = 1 << IDX_BITS;

    // Storage array: written in place, no reset needed since valid bits guard it
    logic [31:0] mem_q [DEPTH];

    always_comb rd_data = mem_q[{rd_set, rd_way, rd_lw}];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[{rd_set, wr_way, wr_lw}] <= wr_data;
    end
endmodule

// File: rtl/dcache2w.sv
module dcache2w
    import dc_pkg::*;
#(
    parameter int SET_BITS  = 6,
    parameter int SUB_BITS  = 2,
    parameter int WORD_BITS = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_stall,
    output logic [31:0] cpu_rdata,
    output logic        cpu_rvalid,
    input  logic        mode_wr,
    input  logic [2:0]  mode_in,
    output logic [2:0]  mode_out,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    localparam int LW_BITS  = SUB_BITS + WORD_BITS;
    localparam int TAG_BITS = 32 - SET_BITS - LW_BITS - 2;
    localparam logic [LW_BITS-1:0] CNT_LAST = '1;

    typedef struct packed {
        dc_state_e           st;
        logic [31:0]         maddr;
        logic [31:0]         wdata;
        logic                vway;
        logic [TAG_BITS-1:0] vtag;
        logic [LW_BITS-1:0]  cnt;
        logic [31:0]         rdata;
        logic                rvalid;
        logic [2:0]          mode;
    } regs_t;

    regs_t r_d, r_q;

    logic [31:0]               cur_addr;
    logic [TAG_BITS-1:0]       a_tag;
    logic [SET_BITS-1:0]       a_set;
    logic [LW_BITS-1:0]        a_lw;
    logic [1:0][TAG_BITS-1:0]  t_tag;
    logic [1:0]                t_valid, t_dirty, hit_v;
    logic                      t_lru, hit, hit_way;
    logic                      fill_en, dirty_en, lru_en, lru_way;
    logic                      d_rway, d_we, d_wway;
    logic [LW_BITS-1:0]        d_rlw, d_wlw;
    logic [31:0]               d_rdata, d_wdata;

    assign cur_addr = (r_q.st == ST_IDLE) ? cpu_addr : r_q.maddr;

    dc_addr_split #(.SET_BITS(SET_BITS), .SUB_BITS(SUB_BITS), .WORD_BITS(WORD_BITS)) u_split (
        .addr(cur_addr), .tag(a_tag), .set_idx(a_set), .line_word(a_lw)
    );

    dc_tags #(.SET_BITS(SET_BITS), .TAG_BITS(TAG_BITS)) u_tags (
        .clk(clk), .rst_n(rst_n), .rd_set(a_set),
        .rd_tag(t_tag), .rd_valid(t_valid), .rd_dirty(t_dirty), .rd_lru(t_lru),
        .fill_en(fill_en), .fill_way(r_q.vway), .fill_tag(a_tag),
        .dirty_en(dirty_en), .dirty_way(hit_way),
        .lru_en(lru_en), .lru_used_way(lru_way)
    );

    dc_data #(.SET_BITS(SET_BITS), .LW_BITS(LW_BITS)) u_data (
        .clk(clk), .rd_set(a_set), .rd_way(d_rway), .rd_lw(d_rlw), .rd_data(d_rdata),
        .wr_en(d_we), .wr_way(d_wway), .wr_lw(d_wlw), .wr_data(d_wdata)
    );

    for (genvar w = 0; w < 2; w++) begin : g_hit
        assign hit_v[w] = t_valid[w] && (t_tag[w] == a_tag);
    end
    assign hit     = |hit_v;
    assign hit_way = hit_v[1];

    always_comb begin
        r_d       = r_q;
        r_d.rvalid = 1'b0;
        fill_en   = 1'b0;
        dirty_en  = 1'b0;
        lru_en    = 1'b0;
        lru_way   = hit_way;
        d_rway    = (r_q.st == ST_IDLE) ? hit_way : r_q.vway;
        d_rlw     = (r_q.st == ST_WB) ? r_q.cnt : a_lw;
        d_we      = 1'b0;
        d_wway    = hit_way;
        d_wlw     = a_lw;
        d_wdata   = cpu_wdata;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        cpu_stall = 1'b1;

        if (mode_wr && (mode_in == MODE_NORMAL || mode_in == MODE_ALT)) begin
            r_d.mode = mode_in;
        end

        unique case (r_q.st)
            ST_IDLE: begin
                cpu_stall = cpu_req && !hit;
                if (cpu_req && hit) begin
                    lru_en = 1'b1;
                    if (cpu_we) begin
                        d_we     = 1'b1;
                        dirty_en = 1'b1;
                    end else begin
                        r_d.rdata  = d_rdata;
                        r_d.rvalid = 1'b1;
                    end
                end else if (cpu_req) begin
                    r_d.maddr = cpu_addr;
                    if (cpu_we) begin
                        r_d.wdata = cpu_wdata;
                        r_d.st    = ST_WFWD;
                    end else begin
                        r_d.vway = t_lru;
                        r_d.vtag = t_tag[t_lru];
                        r_d.cnt  = '0;
                        r_d.st   = (t_valid[t_lru] && t_dirty[t_lru]) ? ST_WB : ST_FILL;
                    end
                end
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {r_q.vtag, a_set, r_q.cnt, 2'b00};
                mem_wdata = d_rdata;
                if (mem_ack) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_LAST) r_d.st = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {a_tag, a_set, r_q.cnt, 2'b00};
                if (mem_ack) begin
                    d_we    = 1'b1;
                    d_wway  = r_q.vway;
                    d_wlw   = r_q.cnt;
                    d_wdata = mem_rdata;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_LAST) begin
                        fill_en = 1'b1;
                        lru_en  = 1'b1;
                        lru_way = r_q.vway;
                        r_d.st  = ST_IDLE;
                    end
                end
            end
            ST_WFWD: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {r_q.maddr[31:2], 2'b00};
                mem_wdata = r_q.wdata;
                if (mem_ack) r_d.st = ST_WDONE;
            end
            ST_WDONE: begin
                cpu_stall = 1'b0;
                r_d.st    = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.mode <= MODE_NORMAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_rdata  = r_q.rdata;
    assign cpu_rvalid = r_q.rvalid;
    assign mode_out   = r_q.mode;

    assert_rvalid_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> $past(cpu_req && !cpu_we && !cpu_stall));

    assert_one_way_hits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && cpu_req) |-> ($countones(hit_v) <= 1));

    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                    && $stable(mem_wdata)));

    assert_stall_during_traffic_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cpu_stall);

    assert_mode_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_out == MODE_NORMAL) || (mode_out == MODE_ALT));
endmodule

// File: tb/sim_dcache2w.sv
module sim_dcache2w;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_stall, cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic        mode_wr = 1'b0;
    logic [2:0]  mode_in = '0;
    logic [2:0]  mode_out;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rd_beats = 0;
    int wr_beats = 0;
    logic [31:0] model [4096];
    logic [31:0] shadow [4096];
    logic [31:0] rd_log [256];
    logic [31:0] wr_log [256];

    always #4 clk = ~clk;

    dcache2w u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall),
        .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid), .mode_wr(mode_wr),
        .mode_in(mode_in), .mode_out(mode_out), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Next-level memory: acknowledges one word every other cycle
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            mem_ack = 1'b1;
            if (mem_we) begin
                model[mem_addr[13:2]] = mem_wdata;
                wr_log[wr_beats % 256] = mem_addr;
                wr_beats++;
            end else begin
                mem_rdata = model[mem_addr[13:2]];
                rd_log[rd_beats % 256] = mem_addr;
                rd_beats++;
            end
        end
    end

    function automatic logic [31:0] mk(input int tg, input int st, input int lw);
        return {tg[20:0], st[5:0], lw[2:0], 2'b00};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output logic rv, output int stalls);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        stalls = 0;
        forever begin
            #3;
            if (!cpu_stall) break;
            stalls++;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        rd = cpu_rdata;
        rv = cpu_rvalid;
        if (we) shadow[addr[13:2]] = wd;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 stall idle", {31'd0, cpu_stall}, 32'd0);
        chk("R1 mode reset", {29'd0, mode_out}, 32'd0);
        chk("R1 no mem req", {31'd0, mem_req}, 32'd0);
        chk("R1 rvalid low", {31'd0, cpu_rvalid}, 32'd0);
    endtask

    task automatic t_read_miss;
        logic [31:0] rd; logic rv; int st; int r0, w0;
        r0 = rd_beats; w0 = wr_beats;
        access(1'b0, mk(1, 5, 3), 32'd0, rd, rv, st);
        chk("R1 first access misses", {31'd0, st > 0}, 32'd1);
        chk("R5 miss data", rd, shadow[mk(1, 5, 3) >> 2]);
        chk("R5 miss rvalid", {31'd0, rv}, 32'd1);
        chk("R10 eight read beats", rd_beats - r0, 32'd8);
        chk("R6 clean victim no write", wr_beats - w0, 32'd0);
        chk("R5 first fill addr", rd_log[r0 % 256], mk(1, 5, 0));
        chk("R5 last fill addr", rd_log[(r0 + 7) % 256], mk(1, 5, 7));
    endtask

    task automatic t_read_hit;
        logic [31:0] rd; logic rv; int st; int r0, w0;
        r0 = rd_beats; w0 = wr_beats;
        access(1'b0, mk(1, 5, 3) | 32'h3, 32'd0, rd, rv, st);
        chk("R2 low bits ignored", rd, shadow[mk(1, 5, 3) >> 2]);
        chk("R3 hit no stall", st, 32'd0);
        chk("R3 hit rvalid", {31'd0, rv}, 32'd1);
        access(1'b0, mk(1, 5, 6), 32'd0, rd, rv, st);
        chk("R2 other subline word", rd, shadow[mk(1, 5, 6) >> 2]);
        chk("R3 hit no traffic", (rd_beats - r0) + (wr_beats - w0), 32'd0);
    endtask

    task automatic t_write_hit;
        logic [31:0] rd; logic rv; int st; int r0, w0; logic [31:0] old;
        r0 = rd_beats; w0 = wr_beats;
        old = model[mk(1, 5, 1) >> 2];
        access(1'b1, mk(1, 5, 1), 32'hCAFE_0001, rd, rv, st);
        chk("R4 write hit no stall", st, 32'd0);
        chk("R4 write hit no traffic", (rd_beats - r0) + (wr_beats - w0), 32'd0);
        chk("R4 next level unchanged", model[mk(1, 5, 1) >> 2], old);
        access(1'b0, mk(1, 5, 1), 32'd0, rd, rv, st);
        chk("R4 readback", rd, 32'hCAFE_0001);
    endtask

    task automatic t_replace;
        logic [31:0] rd; logic rv; int st; int r0, w0;
        r0 = rd_beats; w0 = wr_beats;
        access(1'b0, mk(2, 5, 0), 32'd0, rd, rv, st);
        chk("R5 second way fill", rd_beats - r0, 32'd8);
        chk("R5 second way data", rd, shadow[mk(2, 5, 0) >> 2]);
        access(1'b0, mk(1, 5, 2), 32'd0, rd, rv, st);
        chk("R7 first line kept", st, 32'd0);
        r0 = rd_beats; w0 = wr_beats;
        access(1'b0, mk(3, 5, 7), 32'd0, rd, rv, st);
        chk("R7 clean older way evicted", wr_beats - w0, 32'd0);
        chk("R5 third tag data", rd, shadow[mk(3, 5, 7) >> 2]);
        r0 = rd_beats; w0 = wr_beats;
        access(1'b0, mk(2, 5, 4), 32'd0, rd, rv, st);
        chk("R6 dirty victim written", wr_beats - w0, 32'd8);
        chk("R6 victim base addr", wr_log[w0 % 256], mk(1, 5, 0));
        chk("R6 victim data out", model[mk(1, 5, 1) >> 2], 32'hCAFE_0001);
        chk("R5 refill after wb", rd, shadow[mk(2, 5, 4) >> 2]);
        chk("R6 write-back before fill", {31'd0, rd_beats - r0 == 8}, 32'd1);
        access(1'b0, mk(1, 5, 1), 32'd0, rd, rv, st);
        chk("R6 data survives eviction", rd, 32'hCAFE_0001);
    endtask

    task automatic t_write_miss;
        logic [31:0] rd; logic rv; int st; int r0, w0;
        r0 = rd_beats; w0 = wr_beats;
        access(1'b1, mk(4, 9, 2), 32'h0BAD_F00D, rd, rv, st);
        chk("R8 one write beat", wr_beats - w0, 32'd1);
        chk("R8 no read beats", rd_beats - r0, 32'd0);
        chk("R8 write reached memory", model[mk(4, 9, 2) >> 2], 32'h0BAD_F00D);
        chk("R8 write addr", wr_log[w0 % 256], mk(4, 9, 2));
        r0 = rd_beats;
        access(1'b0, mk(4, 9, 2), 32'd0, rd, rv, st);
        chk("R8 not allocated", rd_beats - r0, 32'd8);
        chk("R8 read after miss", rd, 32'h0BAD_F00D);
    endtask

    task automatic set_mode(input logic [2:0] v);
        @(negedge clk);
        mode_wr = 1'b1; mode_in = v;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic t_mode;
        set_mode(3'b010);
        chk("R9 legal 010", {29'd0, mode_out}, 32'd2);
        set_mode(3'b111);
        chk("R9 reserved 111 ignored", {29'd0, mode_out}, 32'd2);
        set_mode(3'b001);
        chk("R9 reserved 001 ignored", {29'd0, mode_out}, 32'd2);
        set_mode(3'b000);
        chk("R9 legal 000", {29'd0, mode_out}, 32'd0);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            model[i]  = 32'h5A00_0000 + i * 32'h0001_0003;
            shadow[i] = model[i];
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_miss();
        t_read_hit();
        t_write_hit();
        t_replace();
        t_write_miss();
        t_mode();
        repeat (2) @(negedge clk);
        finish_run();
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<50000", cyc);
            finish_run();
        end
    end
endmodule